// File: doc/BRIEF.md
# Divide-by-Three Clock, Ready and Reset Generator

This block produces the processor clock, a half-rate peripheral clock, a wait-state control line and a synchronized reset. It runs on a fast reference clock. Each oscillator source arrives as a digital level, and the block samples that level on the reference clock. A select pin chooses between a crystal-path oscillator and an external clock. The chosen oscillator's rising edges drive a modulo-three phase counter. The processor clock is high in phase 0 only, which gives one third of the oscillator rate with a one-third high duty cycle. When the external clock is in use, a sync pin holds the counter at phase 0, so several generators can be brought into phase.

Two ready sources each come with an active-low enable qualifier. A source takes part only while its qualifier is low. The combined ready is retimed to the generated clock. The wait-state line has two modes: one stage clocked on the falling edge of the generated clock, or two stages clocked on the rising edge and then the falling edge. An active-low reset request passes through two stages clocked on the rising edge of the generated clock and leaves the block as an active-high reset.

All outputs are registered or decoded from state in the reference domain. Every edge of the generated clock therefore lines up with a reference-clock edge.

Top module: `cgen_top`

## Requirements
- R1: The period of `clk_o` is three periods of the selected oscillator.
- R2: `clk_o` is high for exactly one oscillator period in each of its periods.
- R3: With `fc_sel`=0 the oscillator source is `osc_xtal`; with `fc_sel`=1 it is `osc_ext`. The unselected source has no effect on `clk_o`.
- R4: With `fc_sel`=1, holding `csync` high holds `clk_o` high, with the counter kept in phase 0. With `fc_sel`=0, `csync` is ignored and `clk_o` keeps toggling.
- R5: The combined ready is (`rdy_a` AND NOT `aen_a_n`) OR (`rdy_b` AND NOT `aen_b_n`). A ready input whose qualifier is high has no effect on `ready_o`.
- R6: With `amode`=1, `ready_o` takes the combined ready at each falling edge of `clk_o` and changes at no other time.
- R7: With `amode`=0, the combined ready is captured at a rising edge of `clk_o` and reaches `ready_o` at the next falling edge. A change made just after a rising edge therefore does not reach `ready_o` at the next falling edge, only at the one after.
- R8: `reset_o` is NOT `res_n`, delayed by two rising edges of `clk_o`, and changes only at those edges.
- R9: `pclk_o` toggles at every rising edge of `clk_o`, so its high time equals one `clk_o` period.
- R10: While `rst_n` is low: `clk_o`=1, `pclk_o`=0, `ready_o`=0, `reset_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that samples all inputs |
| rst_n | input | 1 | Active-low block reset |
| osc_xtal | input | 1 | Crystal-path oscillator level |
| osc_ext | input | 1 | External clock level |
| fc_sel | input | 1 | Source select: 0 crystal, 1 external |
| csync | input | 1 | Phase sync for the external clock, active high |
| rdy_a | input | 1 | Ready source A |
| aen_a_n | input | 1 | Qualifier for A, active low |
| rdy_b | input | 1 | Ready source B |
| aen_b_n | input | 1 | Qualifier for B, active low |
| amode | input | 1 | Ready depth: 1 single stage, 0 two stages |
| res_n | input | 1 | Active-low reset request |
| clk_o | output | 1 | Generated processor clock |
| pclk_o | output | 1 | Half-rate peripheral clock |
| ready_o | output | 1 | Retimed ready, 0 inserts wait states |
| reset_o | output | 1 | Synchronized reset, active high |

## Verification
The case that is hardest to reach is the difference in depth between the two ready modes. Both modes settle to the same level, so a design that wires the modes the wrong way round still looks correct under slow stimulus. To expose it, the bench waits for a rising edge of `clk_o`, changes the ready inputs in the same half cycle, and then checks `ready_o` at the next falling edge, where the two modes must differ. The reset depth is checked the same way: the request is changed just after a rising edge and `reset_o` is checked at the first and second rising edges that follow.

// File: rtl/cgen_pkg.sv
package cgen_pkg;
  localparam int unsigned DIV_N = 3;
  localparam int unsigned PH_W  = $clog2(DIV_N);
  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_HIGH = '0;
  localparam phase_t PH_LAST = phase_t'(DIV_N - 1);
endpackage

// File: rtl/cgen_src.sv
module cgen_src (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic osc_xtal,
  input  logic osc_ext,
  input  logic fc_sel,
  input  logic csync,
  output logic tick,
  output logic sync_act
);
  logic lvl_q, lvl_prev, sync_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q    <= 1'b0;
      lvl_prev <= 1'b0;
      sync_q   <= 1'b0;
    end else begin
      lvl_q    <= fc_sel ? osc_ext : osc_xtal;
      lvl_prev <= lvl_q;
      sync_q   <= csync;
    end
  end

  assign tick     = lvl_q & ~lvl_prev;
  assign sync_act = sync_q & fc_sel;

  assert_tick_single_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cgen_div.sv
module cgen_div
  import cgen_pkg::*;
(
  input  logic ref_clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_act,
  output logic clk_o,
  output logic pclk_o,
  output logic rise_ev,
  output logic fall_ev
);
  phase_t ph;

  assign rise_ev = sync_act ? (ph != PH_HIGH) : (tick && ph == PH_LAST);
  assign fall_ev = !sync_act && tick && ph == PH_HIGH;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_HIGH;
      pclk_o <= 1'b0;
    end else begin
      if (sync_act)
        ph <= PH_HIGH;
      else if (tick)
        ph <= (ph == PH_LAST) ? PH_HIGH : ph + 1'b1;
      if (rise_ev)
        pclk_o <= ~pclk_o;
    end
  end

  assign clk_o = (ph == PH_HIGH);

  assert_high_one_period_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (tick && clk_o && !sync_act) |=> !clk_o);
  assert_sync_holds_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sync_act |=> clk_o);
  assert_pclk_on_rise_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !rise_ev |=> $stable(pclk_o));
endmodule

// File: rtl/cgen_rdy.sv
module cgen_rdy (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic rdy_a,
  input  logic aen_a_n,
  input  logic rdy_b,
  input  logic aen_b_n,
  input  logic amode,
  output logic ready_o
);
  logic any_rdy, stage1;

  assign any_rdy = (rdy_a & ~aen_a_n) | (rdy_b & ~aen_b_n);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      if (rise_ev)
        stage1 <= any_rdy;
      if (fall_ev)
        ready_o <= amode ? any_rdy : stage1;
    end
  end

  assert_ready_on_fall_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !fall_ev |=> $stable(ready_o));
endmodule

// File: rtl/cgen_rst.sv
module cgen_rst (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rise_ev,
  input  logic res_n,
  output logic reset_o
);
  logic q1;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      q1      <= 1'b1;
      reset_o <= 1'b1;
    end else if (rise_ev) begin
      q1      <= ~res_n;
      reset_o <= q1;
    end
  end

  assert_reset_on_rise_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !rise_ev |=> $stable(reset_o));
endmodule

// File: rtl/cgen_top.sv
module cgen_top (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic osc_xtal,
  input  logic osc_ext,
  input  logic fc_sel,
  input  logic csync,
  input  logic rdy_a,
  input  logic aen_a_n,
  input  logic rdy_b,
  input  logic aen_b_n,
  input  logic amode,
  input  logic res_n,
  output logic clk_o,
  output logic pclk_o,
  output logic ready_o,
  output logic reset_o
);
  logic tick, sync_act, rise_ev, fall_ev;

  cgen_src u_src (
    .ref_clk(ref_clk), .rst_n(rst_n), .osc_xtal(osc_xtal), .osc_ext(osc_ext),
    .fc_sel(fc_sel), .csync(csync), .tick(tick), .sync_act(sync_act)
  );

  cgen_div u_div (
    .ref_clk(ref_clk), .rst_n(rst_n), .tick(tick), .sync_act(sync_act),
    .clk_o(clk_o), .pclk_o(pclk_o), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  cgen_rdy u_rdy (
    .ref_clk(ref_clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rdy_a(rdy_a), .aen_a_n(aen_a_n), .rdy_b(rdy_b), .aen_b_n(aen_b_n),
    .amode(amode), .ready_o(ready_o)
  );

  cgen_rst u_rst (
    .ref_clk(ref_clk), .rst_n(rst_n), .rise_ev(rise_ev), .res_n(res_n),
    .reset_o(reset_o)
  );

  assert_edges_exclusive_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(rise_ev && fall_ev));
endmodule

// File: tb/sim_cgen_top.sv
module sim_cgen_top;
  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_xtal = 1'b0, osc_ext = 1'b0, fc_sel = 1'b0, csync = 1'b0;
  logic rdy_a = 1'b0, aen_a_n = 1'b1, rdy_b = 1'b0, aen_b_n = 1'b1;
  logic amode = 1'b1, res_n = 1'b0;
  logic clk_o, pclk_o, ready_o, reset_o;

  int total = 0, bad = 0, cyc = 0;
  int xt_half = 3, ex_half = 4;

  typedef struct { int per; int hi; } item_t;
  item_t sb[$];
  bit mon_en = 0;
  int exp_pclk_hi = 0;

  always #5 ref_clk = ~ref_clk;
  always @(posedge ref_clk) cyc <= cyc + 1;

  initial forever begin
    repeat (xt_half) @(negedge ref_clk);
    osc_xtal = ~osc_xtal;
  end
  initial forever begin
    repeat (ex_half) @(negedge ref_clk);
    osc_ext = ~osc_ext;
  end

  cgen_top u0 (
    .ref_clk(ref_clk), .rst_n(rst_n), .osc_xtal(osc_xtal), .osc_ext(osc_ext),
    .fc_sel(fc_sel), .csync(csync), .rdy_a(rdy_a), .aen_a_n(aen_a_n),
    .rdy_b(rdy_b), .aen_b_n(aen_b_n), .amode(amode), .res_n(res_n),
    .clk_o(clk_o), .pclk_o(pclk_o), .ready_o(ready_o), .reset_o(reset_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures CLK period/high time and pops expected items
  bit last_clk = 1'b1, last_pclk = 1'b0, have_start = 0, p_start = 0;
  int t_rise = 0, t_hi = 0, tp_rise = 0;
  always @(negedge ref_clk) begin
    if (!mon_en) begin
      have_start = 0;
      p_start = 0;
    end
    if (clk_o && !last_clk) begin
      if (have_start && sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check("R1 clk period", cyc - t_rise, it.per);
        check("R2 clk high", t_hi, it.hi);
      end
      have_start = mon_en;
      t_rise = cyc;
    end
    if (!clk_o && last_clk) t_hi = cyc - t_rise;
    if (pclk_o && !last_pclk) begin
      tp_rise = cyc;
      p_start = mon_en;
    end
    if (!pclk_o && last_pclk && p_start)
      check("R9 pclk high", cyc - tp_rise, exp_pclk_hi);
    last_clk = clk_o;
    last_pclk = pclk_o;
  end

  task automatic wait_edge(input bit rise);
    logic last;
    last = clk_o;
    forever begin
      @(negedge ref_clk);
      if (rise ? (clk_o && !last) : (!clk_o && last)) break;
      last = clk_o;
    end
  endtask

  task automatic drive_periods(input int n, input int half);
    mon_en = 0;
    sb.delete();
    repeat (3) wait_edge(1);
    exp_pclk_hi = 6 * half;
    for (int i = 0; i < n; i++) sb.push_back('{6 * half, 2 * half});
    mon_en = 1;
    while (sb.size() > 0) @(negedge ref_clk);
    mon_en = 0;
  endtask

  initial begin
    int lows;
    repeat (3) @(negedge ref_clk);
    // R10 reset state
    check("R10 clk_o", clk_o, 1);
    check("R10 pclk_o", pclk_o, 0);
    check("R10 ready_o", ready_o, 0);
    check("R10 reset_o", reset_o, 1);
    rst_n = 1'b1;

    // R1 R2 R3 R9: crystal source, then external source
    drive_periods(4, xt_half);
    fc_sel = 1'b1;
    drive_periods(4, ex_half);
    fc_sel = 1'b0;
    ex_half = 5;   // R3: unselected source changes, period must not
    drive_periods(3, xt_half);

    // R4: sync holds CLK high with external source
    fc_sel = 1'b1;
    wait_edge(0);
    csync = 1'b1;
    repeat (3) @(negedge ref_clk);
    lows = 0;
    repeat (30) begin @(negedge ref_clk); if (!clk_o) lows++; end
    check("R4 sync holds clk high", lows, 0);
    csync = 1'b0;
    // R4: sync ignored with crystal source
    fc_sel = 1'b0;
    repeat (20) @(negedge ref_clk);
    csync = 1'b1;
    lows = 0;
    repeat (40) begin @(negedge ref_clk); if (!clk_o) lows++; end
    check("R4 sync ignored on crystal", lows > 0, 1);
    csync = 1'b0;

    // R5: qualifiers
    amode = 1'b1;
    rdy_a = 1'b1; aen_a_n = 1'b1; rdy_b = 1'b1; aen_b_n = 1'b1;
    repeat (2) wait_edge(0);
    check("R5 both disqualified", ready_o, 0);
    aen_b_n = 1'b0;
    repeat (2) wait_edge(0);
    check("R5 source B qualified", ready_o, 1);
    rdy_b = 1'b0; aen_a_n = 1'b0;
    repeat (2) wait_edge(0);
    check("R5 source A qualified", ready_o, 1);
    rdy_a = 1'b0;
    repeat (2) wait_edge(0);
    check("R5 both low", ready_o, 0);

    // R6: single stage, change after rise visible at next fall
    wait_edge(1);
    rdy_a = 1'b1;
    wait_edge(0);
    check("R6 single stage", ready_o, 1);
    rdy_a = 1'b0;
    repeat (2) wait_edge(0);

    // R7: two stages, change after rise not visible at next fall
    amode = 1'b0;
    repeat (2) wait_edge(0);
    wait_edge(1);
    rdy_a = 1'b1;
    wait_edge(0);
    check("R7 two stage first fall", ready_o, 0);
    wait_edge(0);
    check("R7 two stage second fall", ready_o, 1);

    // R8: reset depth
    res_n = 1'b1;
    repeat (3) wait_edge(1);
    check("R8 reset released", reset_o, 0);
    res_n = 1'b0;
    wait_edge(1);
    check("R8 after one rise", reset_o, 0);
    wait_edge(1);
    check("R8 after two rises", reset_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule